// File: doc/BRIEF.md
# Island Voltage-Frequency Level Governor

This block chooses the operating level of one voltage-frequency island. Every router of the island reports, through decoded notifications, whether it wants the island sped up (some input queue above the high occupancy mark) or slowed down (all queues under the low mark). Each notification names one router and carries both of its request bits. The governor keeps one raise bit and one lower bit per router. At each poll tick it turns the two request vectors into a new level index for an external regulator model.

A raise request from any router outranks every lower request. When the island sits at the minimum level, a raise moves it in one transition to the highest level allowed. From a level above the minimum, a raise moves up one step. A lower request, when no router asks to raise, moves down one step, and the level never goes below zero.

An optional ceiling caps the highest reachable level. After every level change a busy flag stays high for a programmable number of cycles to model the regulator's settling time. A poll tick that lands inside that window is not lost: it is held and acted on once the window ends. Notifications are still recorded while the flag is high.

Top module: `island_level_governor`

## Requirements
- R1: After reset the level output is 0, busy is low, and every raise and lower request bit is clear.
- R2: A notification for router r replaces both stored bits of router r with the notification's raise and lower bits. The bits of other routers are left as they were.
- R3: If any router has its raise bit set, the level never goes down, even if other routers have their lower bit set.
- R4: If at least one lower bit is set and no raise bit is set, a decision moves the level down by exactly one. At level 0 the level stays at 0.
- R5: If any raise bit is set at level 0, a decision moves the level in one change to the effective ceiling. With the ceiling disabled, the effective ceiling is MAX_LEVEL.
- R6: If any raise bit is set at a level between 1 and the effective ceiling minus one, a decision moves the level up by exactly one. At the effective ceiling or above it, the level stays where it is.
- R7: When ceilingEn is 1, the effective ceiling is ceilingLevel, limited to at most MAX_LEVEL.
- R8: Decisions are taken only on poll ticks. A tick occurs on the pollPeriod-th rising edge after reset is released and then on every pollPeriod-th edge after that. A pollPeriod of 0 behaves like 1.
- R9: After a level change, busy is high for exactly holdCycles cycles, starting in the cycle right after the change. With holdCycles equal to 0, busy stays low.
- R10: While busy is high, the level does not change. A poll tick that occurs while busy is high is carried out on the first edge at which busy is low, using the request bits recorded up to that point.
- R11: With no request bits set, the level stays unchanged on every tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| notifValid | input | 1 | A decoded notification is present this cycle |
| notifRouter | input | $clog2(NUM_ROUTERS) | Index of the router within the island |
| notifRaise | input | 1 | The router's raise request bit |
| notifLower | input | 1 | The router's lower request bit |
| ceilingEn | input | 1 | Enables the level ceiling |
| ceilingLevel | input | $clog2(MAX_LEVEL+1) | Highest reachable level when the ceiling is enabled |
| pollPeriod | input | POLL_W | Cycles between decisions |
| holdCycles | input | HOLD_W | Length of the busy window after each change |
| level | output | $clog2(MAX_LEVEL+1) | Current level index, 0 being the slowest |
| busy | output | 1 | A level transition is settling |

## Verification
The hardest case to reach is a poll tick that falls inside the busy window, where the decision must be deferred rather than dropped. Seen from the ports, this is only visible as a change that comes one cycle before the next regular tick. The stimulus sets a poll period of 4 and a hold of 6 cycles. It triggers the jump on the first tick and then records a lower request while busy is high. Because the period is shorter than the hold, the second tick falls inside the window, and the bench checks that the step down lands on the first edge after busy falls, not on the third tick. Ceiling changes made while a raise request stays set walk the level up one step at a time, which makes the step-up and clamping rules visible edge by edge.

// File: rtl/vfi_level_pkg.sv
package vfi_level_pkg;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_JUMP = 2'd1,
    ACT_UP   = 2'd2,
    ACT_DOWN = 2'd3
  } lvlAct_e;

  typedef struct packed {
    logic    fire;
    lvlAct_e act;
  } lvlStrobe_t;

endpackage

// File: rtl/vfi_level_dp.sv
module vfi_level_dp
  import vfi_level_pkg::*;
#(
  parameter int NUM_ROUTERS = 8,
  parameter int MAX_LEVEL   = 6,
  parameter int IDX_W       = 3,
  parameter int LVL_W       = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   notifValid,
  input  logic [IDX_W-1:0]       notifRouter,
  input  logic                   notifRaise,
  input  logic                   notifLower,
  input  logic                   ceilingEn,
  input  logic [LVL_W-1:0]       ceilingLevel,
  input  lvlStrobe_t             strobe,
  output logic [LVL_W-1:0]       level,
  output logic [LVL_W-1:0]       effCeil,
  output logic                   anyRaise,
  output logic                   anyLower,
  output logic [NUM_ROUTERS-1:0] raiseVec,
  output logic [NUM_ROUTERS-1:0] lowerVec
);

  localparam logic [LVL_W-1:0] MAX_L = LVL_W'(MAX_LEVEL);

  // One request slot per router of the island
  for (genvar r = 0; r < NUM_ROUTERS; r++) begin : g_slot
    logic slotHit;
    assign slotHit = notifValid && (notifRouter == IDX_W'(r));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        raiseVec[r] <= 1'b0;
        lowerVec[r] <= 1'b0;
      end else if (slotHit) begin
        raiseVec[r] <= notifRaise;
        lowerVec[r] <= notifLower;
      end
    end
  end

  assign anyRaise = |raiseVec;
  assign anyLower = |lowerVec;

  always_comb begin
    if (ceilingEn) begin
      effCeil = (ceilingLevel > MAX_L) ? MAX_L : ceilingLevel;
    end else begin
      effCeil = MAX_L;
    end
  end

  logic [LVL_W-1:0] levelNext;

  always_comb begin
    levelNext = level;
    unique case (strobe.act)
      ACT_JUMP: levelNext = effCeil;
      ACT_UP:   levelNext = level + LVL_W'(1);
      ACT_DOWN: levelNext = level - LVL_W'(1);
      default:  levelNext = level;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      level <= '0;
    end else if (strobe.fire) begin
      level <= levelNext;
    end
  end

endmodule

// File: rtl/vfi_level_ctrl.sv
module vfi_level_ctrl
  import vfi_level_pkg::*;
#(
  parameter int LVL_W  = 3,
  parameter int POLL_W = 16,
  parameter int HOLD_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [POLL_W-1:0] pollPeriod,
  input  logic [HOLD_W-1:0] holdCycles,
  input  logic [LVL_W-1:0]  level,
  input  logic [LVL_W-1:0]  effCeil,
  input  logic              anyRaise,
  input  logic              anyLower,
  output lvlStrobe_t        strobe,
  output logic              busy
);

  logic [POLL_W-1:0] pollCnt;
  logic [HOLD_W-1:0] holdCnt;
  logic              pending;
  logic              pollTick;
  logic              evaluate;
  lvlAct_e           act;

  // Poll timer: a tick on every pollPeriod-th edge (0 behaves like 1)
  assign pollTick = (pollPeriod <= POLL_W'(1)) ||
                    (pollCnt >= (pollPeriod - POLL_W'(1)));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pollCnt <= '0;
    end else if (pollTick) begin
      pollCnt <= '0;
    end else begin
      pollCnt <= pollCnt + POLL_W'(1);
    end
  end

  assign busy     = (holdCnt != '0);
  assign evaluate = (pollTick || pending) && !busy;

  // A tick that falls inside the settle window is held until it ends
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= 1'b0;
    end else if (evaluate) begin
      pending <= 1'b0;
    end else if (pollTick && busy) begin
      pending <= 1'b1;
    end
  end

  // Level decision: raise outranks lower
  always_comb begin
    act = ACT_HOLD;
    if (anyRaise) begin
      if ((level == '0) && (effCeil != '0)) begin
        act = ACT_JUMP;
      end else if (level < effCeil) begin
        act = ACT_UP;
      end
    end else if (anyLower && (level != '0)) begin
      act = ACT_DOWN;
    end
  end

  always_comb begin
    strobe.act  = act;
    strobe.fire = evaluate && (act != ACT_HOLD);
  end

  // Settle window after each change
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCnt <= '0;
    end else if (strobe.fire) begin
      holdCnt <= holdCycles;
    end else if (holdCnt != '0) begin
      holdCnt <= holdCnt - HOLD_W'(1);
    end
  end

endmodule

// File: rtl/island_level_governor.sv
module island_level_governor
  import vfi_level_pkg::*;
#(
  parameter int NUM_ROUTERS = 8,
  parameter int MAX_LEVEL   = 6,
  parameter int POLL_W      = 16,
  parameter int HOLD_W      = 12
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             notifValid,
  input  logic [$clog2(NUM_ROUTERS)-1:0]   notifRouter,
  input  logic                             notifRaise,
  input  logic                             notifLower,
  input  logic                             ceilingEn,
  input  logic [$clog2(MAX_LEVEL+1)-1:0]   ceilingLevel,
  input  logic [POLL_W-1:0]                pollPeriod,
  input  logic [HOLD_W-1:0]                holdCycles,
  output logic [$clog2(MAX_LEVEL+1)-1:0]   level,
  output logic                             busy
);

  localparam int IDX_W = $clog2(NUM_ROUTERS);
  localparam int LVL_W = $clog2(MAX_LEVEL + 1);

  lvlStrobe_t             strobe;
  logic [LVL_W-1:0]       effCeil;
  logic                   anyRaise;
  logic                   anyLower;
  logic [NUM_ROUTERS-1:0] raiseVec;
  logic [NUM_ROUTERS-1:0] lowerVec;

  vfi_level_dp #(
    .NUM_ROUTERS(NUM_ROUTERS),
    .MAX_LEVEL  (MAX_LEVEL),
    .IDX_W      (IDX_W),
    .LVL_W      (LVL_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .notifValid  (notifValid),
    .notifRouter (notifRouter),
    .notifRaise  (notifRaise),
    .notifLower  (notifLower),
    .ceilingEn   (ceilingEn),
    .ceilingLevel(ceilingLevel),
    .strobe      (strobe),
    .level       (level),
    .effCeil     (effCeil),
    .anyRaise    (anyRaise),
    .anyLower    (anyLower),
    .raiseVec    (raiseVec),
    .lowerVec    (lowerVec)
  );

  vfi_level_ctrl #(
    .LVL_W (LVL_W),
    .POLL_W(POLL_W),
    .HOLD_W(HOLD_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .pollPeriod(pollPeriod),
    .holdCycles(holdCycles),
    .level     (level),
    .effCeil   (effCeil),
    .anyRaise  (anyRaise),
    .anyLower  (anyLower),
    .strobe    (strobe),
    .busy      (busy)
  );

endmodule

// File: rtl/island_level_governor_chk.sv
module island_level_governor_chk #(
  parameter int NUM_ROUTERS = 8,
  parameter int MAX_LEVEL   = 6,
  parameter int HOLD_W      = 12
) (
  input logic                           clk,
  input logic                           rstN,
  input logic                           ceilingEn,
  input logic [$clog2(MAX_LEVEL+1)-1:0] ceilingLevel,
  input logic [HOLD_W-1:0]              holdCycles,
  input logic [$clog2(MAX_LEVEL+1)-1:0] level,
  input logic                           busy,
  input logic [NUM_ROUTERS-1:0]         raiseVec,
  input logic [NUM_ROUTERS-1:0]         lowerVec
);

  localparam int LVL_W = $clog2(MAX_LEVEL + 1);
  localparam logic [LVL_W-1:0] MAX_L = LVL_W'(MAX_LEVEL);

  always @(posedge clk) begin
    if (!rstN) begin
      AST_RESET_CLEAR: assert (level == '0 && !busy && raiseVec == '0 && lowerVec == '0); // R1
    end
  end

  AST_LEVEL_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    level <= MAX_L); // R7

  AST_NO_DROP_ON_RAISE: assert property (@(posedge clk) disable iff (!rstN)
    (level < $past(level)) |-> ($past(raiseVec) == '0)); // R3

  AST_DOWN_ONE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (level < $past(level)) |-> (level == $past(level) - LVL_W'(1))); // R4

  AST_JUMP_TO_CEILING: assert property (@(posedge clk) disable iff (!rstN)
    ($past(level) == '0 && level != '0) |->
      (level == ($past(ceilingEn) ?
                 (($past(ceilingLevel) > MAX_L) ? MAX_L : $past(ceilingLevel)) :
                 MAX_L))); // R5

  AST_UP_ONE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (level > $past(level) && $past(level) != '0) |->
      (level == $past(level) + LVL_W'(1))); // R6

  AST_SETTLE_STARTS: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(level) && $past(holdCycles) != '0) |-> busy); // R9

  AST_FROZEN_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(level)); // R10

endmodule

bind island_level_governor island_level_governor_chk #(
  .NUM_ROUTERS(NUM_ROUTERS),
  .MAX_LEVEL  (MAX_LEVEL),
  .HOLD_W     (HOLD_W)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .ceilingEn   (ceilingEn),
  .ceilingLevel(ceilingLevel),
  .holdCycles  (holdCycles),
  .level       (level),
  .busy        (busy),
  .raiseVec    (raiseVec),
  .lowerVec    (lowerVec)
);

// File: tb/test_island_level_governor.sv
module test_island_level_governor;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        notifValid = 1'b0;
  logic [2:0]  notifRouter = '0;
  logic        notifRaise = 1'b0;
  logic        notifLower = 1'b0;
  logic        ceilingEn = 1'b0;
  logic [2:0]  ceilingLevel = '0;
  logic [15:0] pollPeriod = 16'd1;
  logic [11:0] holdCycles = '0;
  logic [2:0]  level;
  logic        busy;

  int nTests = 0;
  int nFail  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  island_level_governor i_island_level_governor (
    .clk         (clk),
    .rstN        (rstN),
    .notifValid  (notifValid),
    .notifRouter (notifRouter),
    .notifRaise  (notifRaise),
    .notifLower  (notifLower),
    .ceilingEn   (ceilingEn),
    .ceilingLevel(ceilingLevel),
    .pollPeriod  (pollPeriod),
    .holdCycles  (holdCycles),
    .level       (level),
    .busy        (busy)
  );

  task automatic check(input string tag, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Leaves the bench at a falling edge right after reset release
  task automatic doReset(input int p, input int h, input bit cEn, input int cLvl);
    @(negedge clk);
    rstN = 1'b0;
    notifValid = 1'b0;
    pollPeriod = 16'(p);
    holdCycles = 12'(h);
    ceilingEn = cEn;
    ceilingLevel = 3'(cLvl);
    waitCycles(3);
    rstN = 1'b1;
  endtask

  // Drives for one edge; returns at the falling edge after it
  task automatic sendNotif(input int r, input bit up, input bit dn);
    notifValid = 1'b1;
    notifRouter = 3'(r);
    notifRaise = up;
    notifLower = dn;
    @(negedge clk);
    notifValid = 1'b0;
  endtask

  task automatic tResetIdle;
    doReset(1, 0, 0, 0);
    check("R1 level after reset", level, 0);
    check("R1 busy after reset", busy, 0);
    waitCycles(5);
    check("R11 no requests keeps level", level, 0);
  endtask

  task automatic tJumpAndStepDown;
    doReset(1, 0, 0, 0);
    sendNotif(3, 1, 0);
    check("R8 no change before tick sees request", level, 0);
    waitCycles(1);
    check("R5 jump from zero to max", level, 6);
    waitCycles(3);
    check("R6 stays at ceiling", level, 6);
    check("R9 zero hold never busy", busy, 0);
    sendNotif(3, 0, 1);
    check("R2 old raise still in force at that edge", level, 6);
    waitCycles(1);
    check("R2 overwrite lets level drop / R4 one step", level, 5);
    waitCycles(1);
    check("R4 second step", level, 4);
    waitCycles(10);
    check("R4 saturates at zero", level, 0);
  endtask

  task automatic tRaiseWins;
    doReset(1, 0, 0, 0);
    sendNotif(1, 0, 1);
    waitCycles(2);
    check("R4 lower at zero stays zero", level, 0);
    sendNotif(5, 1, 0);
    waitCycles(1);
    check("R3 raise beats lower", level, 6);
    waitCycles(3);
    check("R3 no drop while raise set", level, 6);
    sendNotif(2, 0, 1);
    waitCycles(2);
    check("R2 other router leaves raise intact", level, 6);
  endtask

  task automatic tCeiling;
    doReset(1, 0, 1, 3);
    sendNotif(2, 1, 0);
    waitCycles(1);
    check("R7 jump limited to ceiling", level, 3);
    waitCycles(2);
    check("R7 held at ceiling", level, 3);
    ceilingLevel = 3'd5;
    waitCycles(1);
    check("R6 step up by one", level, 4);
    waitCycles(1);
    check("R6 step up to new ceiling", level, 5);
    waitCycles(2);
    check("R6 held at new ceiling", level, 5);
    ceilingLevel = 3'd7;
    waitCycles(1);
    check("R7 ceiling above max clamps", level, 6);
    waitCycles(2);
    check("R7 clamp holds at max", level, 6);
  endtask

  task automatic tPollPeriod;
    doReset(5, 0, 0, 0);
    sendNotif(0, 1, 0);
    check("R8 edge 1 no decision", level, 0);
    waitCycles(3);
    check("R8 edge 4 no decision", level, 0);
    waitCycles(1);
    check("R8 decision on edge 5", level, 6);
    sendNotif(0, 0, 1);
    waitCycles(3);
    check("R8 edge 9 no decision", level, 6);
    waitCycles(1);
    check("R8 decision on edge 10", level, 5);
    doReset(0, 0, 0, 0);
    sendNotif(0, 1, 0);
    waitCycles(1);
    check("R8 period zero acts as one", level, 6);
  endtask

  task automatic tHoldWindow;
    doReset(1, 3, 0, 0);
    sendNotif(4, 1, 0);
    waitCycles(1);
    check("R9 level after change", level, 6);
    check("R9 busy starts after change", busy, 1);
    sendNotif(4, 0, 1);
    check("R10 busy at edge 3", busy, 1);
    check("R10 level frozen", level, 6);
    waitCycles(1);
    check("R9 busy at edge 4", busy, 1);
    waitCycles(1);
    check("R9 busy clears after three cycles", busy, 0);
    check("R10 still frozen at edge 5", level, 6);
    waitCycles(1);
    check("R10 recorded request acted on", level, 5);
    check("R9 busy again after second change", busy, 1);
    waitCycles(3);
    check("R9 busy cleared again", busy, 0);
    waitCycles(1);
    check("R4 next step after window", level, 4);
  endtask

  task automatic tDeferredTick;
    doReset(4, 6, 0, 0);
    sendNotif(4, 1, 0);
    waitCycles(3);
    check("R8 jump on edge 4", level, 6);
    check("R9 busy after jump", busy, 1);
    sendNotif(4, 0, 1);
    waitCycles(5);
    check("R9 busy ends after six cycles", busy, 0);
    check("R10 no change inside window", level, 6);
    waitCycles(1);
    check("R10 held tick acted on at edge 11", level, 5);
  endtask

  initial begin
    tResetIdle();
    tJumpAndStepDown();
    tRaiseWins();
    tCeiling();
    tPollPeriod();
    tHoldWindow();
    tDeferredTick();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

endmodule